// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block takes eight asynchronous external interrupt pins, brings each one into the clock domain and detects an event on it. What counts as an event is set per pin: a low level, a falling edge, a rising edge or either edge. A detected event sets that pin's bit in a status register. The status bit then drives an active-high level request to a parent interrupt controller until software clears it.

Software reaches the block through a simple single-cycle register port with valid, write, address, write-data and read-data signals. A sense-configuration register holds a 2-bit mode for each pin. The status register holds the latched events. Reads return their data in the same cycle. Writes take effect at the clock edge on which they are presented.

Top module: `irq_sense_latch`

## Requirements
- R1: After reset every sense field is 0 and every status bit is 0, so `irqReq` is 0. The synchroniser stages reset high, so a pin held high through reset raises no event.
- R2: The sense register sits at byte offset 0x14 and holds pin n's mode in bits [2n+1:2n]. A write loads bits [15:0] and a read returns them, with bits [31:16] reading as 0.
- R3: With mode 0 (low level), a pin's status bit is set on every clock edge on which its synchronised sample is low.
- R4: With mode 1 (falling edge), the status bit is set when the synchronised sample goes from 1 to 0.
- R5: With mode 2 (rising edge), the status bit is set when the synchronised sample goes from 0 to 1.
- R6: With mode 3 (both edges), the status bit is set on any change of the synchronised sample.
- R7: The status register sits at byte offset 0x10, with pin n at bit n and bits [31:8] reading as 0. `irqReq[n]` is high exactly while status bit n is set.
- R8: A write to the status register clears each bit written as 0. Bits written as 1 keep their value, so writing 1 never sets a bit.
- R9: If a detection and a clearing write hit the same bit on the same edge, the bit stays set. A low-level pin that is still low therefore holds its bit set across a clear.
- R10: A pin change applied between clock edges shows in status and `irqReq` after the third following rising edge, and not after the second.
- R11: Reads from any offset other than 0x10 and 0x14 return 0. Writes to such offsets change no state.
- R12: In the edge modes, a status bit stays set after the pin returns to its former level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 8 | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irqPin | input | 8 | Asynchronous external interrupt pins |
| irqReq | output | 8 | Active-high level requests to the parent controller |

## Verification
A pin change takes three rising edges to reach status: two synchroniser flops, then the status flop. The bench changes pins half a cycle away from an edge and waits at least four edges before it reads status. The latency test samples `irqReq` just after the second and just after the third edge, which pins down the exact cycle. Register writes update state at the edge that takes them, so the bench reads them back from the following cycle onward. Reads are combinational and are sampled within the cycle that presents them. The same-edge clear test checks `irqReq` just after the edge that carried the clearing write.

// File: rtl/irqsl_pkg.sv
package irqsl_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } senseT;

  typedef struct packed {
    logic wrSense;
    logic wrStatus;
  } strobeT;

endpackage

// File: rtl/irqsl_ctrl.sv
module irqsl_ctrl
  import irqsl_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 'h10,
  parameter int SENSE_OFS  = 'h14
) (
  input  logic                  regValid,
  input  logic                  regWrite,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [2*NUM_PINS-1:0] senseQ,
  input  logic [NUM_PINS-1:0]   statusQ,
  output strobeT                strb,
  output logic [DATA_W-1:0]     regRdata
);

  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] SenseAddr  = ADDR_W'(SENSE_OFS);

  logic hitStatus, hitSense, isRead;

  assign hitStatus = (regAddr == StatusAddr);
  assign hitSense  = (regAddr == SenseAddr);
  assign isRead    = regValid && !regWrite;

  always_comb begin
    strb.wrStatus = regValid && regWrite && hitStatus;
    strb.wrSense  = regValid && regWrite && hitSense;
  end

  always_comb begin
    regRdata = '0;
    if (isRead && hitSense)  regRdata[2*NUM_PINS-1:0] = senseQ;
    if (isRead && hitStatus) regRdata[NUM_PINS-1:0]   = statusQ;
  end

endmodule

// File: rtl/irqsl_datapath.sv
module irqsl_datapath
  import irqsl_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strb,
  input  logic [2*NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0]   irqPin,
  output logic [2*NUM_PINS-1:0] senseQ,
  output logic [NUM_PINS-1:0]   statusQ
);

  localparam int SenseW = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] syncA, syncB, prevQ, hit, keepMask, statusD;

  // two-flop synchroniser plus one history stage; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
      prevQ <= '1;
    end else begin
      syncA <= irqPin;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_detect
    senseT mode;
    assign mode = senseT'(senseQ[2*n +: 2]);
    always_comb begin
      unique case (mode)
        SENSE_LOW:  hit[n] = !syncB[n];
        SENSE_FALL: hit[n] = prevQ[n] && !syncB[n];
        SENSE_RISE: hit[n] = !prevQ[n] && syncB[n];
        SENSE_BOTH: hit[n] = prevQ[n] ^ syncB[n];
        default:    hit[n] = 1'b0;
      endcase
    end

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (senseQ[2*n +: 2] == 2'd0 && !syncB[n]) |=> statusQ[n]); // R3
  end

  assign keepMask = strb.wrStatus ? wdata[NUM_PINS-1:0] : '1;
  assign statusD  = (statusQ & keepMask) | hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseQ  <= '0;
      statusQ <= '0;
    end else begin
      statusQ <= statusD;
      if (strb.wrSense) senseQ <= wdata[SenseW-1:0];
    end
  end

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(hit)) == '0)); // R8

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~statusQ &
      ~($past(strb.wrStatus) ? ~$past(wdata[NUM_PINS-1:0]) : '0)) == '0)); // R8

  AST_SENSE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSense |=> (senseQ == $past(wdata))); // R2

endmodule

// File: rtl/irq_sense_latch.sv
module irq_sense_latch
  import irqsl_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 'h10,
  parameter int SENSE_OFS  = 'h14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regValid,
  input  logic                regWrite,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] irqPin,
  output logic [NUM_PINS-1:0] irqReq
);

  localparam int SenseW = 2 * NUM_PINS;

  strobeT              strb;
  logic [SenseW-1:0]   senseQ;
  logic [NUM_PINS-1:0] statusQ;
  logic                unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:SenseW];

  irqsl_ctrl #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_OFS(STATUS_OFS), .SENSE_OFS(SENSE_OFS)
  ) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .senseQ  (senseQ),
    .statusQ (statusQ),
    .strb    (strb),
    .regRdata(regRdata)
  );

  irqsl_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (regWdata[SenseW-1:0]),
    .irqPin (irqPin),
    .senseQ (senseQ),
    .statusQ(statusQ)
  );

  assign irqReq = statusQ;

endmodule

// File: tb/tb_irq_sense_latch.sv
module tb_irq_sense_latch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  irqPin = 8'hFF;
  logic [7:0]  irqReq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sense_latch dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .irqPin(irqPin), .irqReq(irqReq)
  );

  // sense[15:0], pinA[7:0], pinB[7:0]
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h5555, 8'hFF, 8'h00},
    {16'hAAAA, 8'h00, 8'hFF},
    {16'hAAAA, 8'hFF, 8'h00},
    {16'hFFFF, 8'h0F, 8'hF0},
    {16'h0000, 8'hFF, 8'hFF},
    {16'h0000, 8'hFF, 8'h5A},
    {16'hE4E4, 8'hAA, 8'h55},
    {16'h1B1B, 8'h33, 8'hCC}
  };

  function automatic logic [7:0] model(logic [15:0] s, logic [7:0] a, logic [7:0] b);
    logic [7:0] r = '0;
    for (int n = 0; n < 8; n++) begin
      case (s[2*n +: 2])
        2'd0: r[n] = !a[n] || !b[n];
        2'd1: r[n] = a[n] && !b[n];
        2'd2: r[n] = !a[n] && b[n];
        default: r[n] = a[n] != b[n];
      endcase
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1 reset state
    rd(8'h14, r); check("R1 sense reset", r, 32'h0);
    rd(8'h10, r); check("R1 status reset", r, 32'h0);
    check("R1 irqReq reset", {24'h0, irqReq}, 32'h0);

    // R2 sense readback, upper bits read zero
    wr(8'h14, 32'hFFFF_1234);
    rd(8'h14, r); check("R2 sense readback", r, 32'h0000_1234);

    // R11 unmapped read and write
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R11 unmapped read", r, 32'h0);
    rd(8'h14, r); check("R11 unmapped write ignored", r, 32'h0000_1234);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      wr(8'h14, {16'h0, VEC[v][31:16]});
      irqPin = VEC[v][15:8];
      settle();
      wr(8'h10, 32'h0);
      irqPin = VEC[v][7:0];
      settle();
      e = model(VEC[v][31:16], VEC[v][15:8], VEC[v][7:0]);
      rd(8'h10, r); check("R3/R4/R5/R6 vector status", r, {24'h0, e});
      check("R7 irqReq mirrors status", {24'h0, irqReq}, {24'h0, e});
    end

    // R8 write-one no effect, selective clear
    irqPin = 8'hFF; wr(8'h14, 32'h5555); settle(); wr(8'h10, 32'h0);
    wr(8'h10, 32'hFF); settle();
    check("R8 write one ignored", {24'h0, irqReq}, 32'h0);
    irqPin = 8'h00; settle();
    wr(8'h10, 32'hF0);
    rd(8'h10, r); check("R8 selective clear", r, 32'hF0);

    // R12 latched after pin returns
    irqPin = 8'hFF; settle();
    check("R12 held after release", {24'h0, irqReq}, 32'hF0);

    // R10 latency, rising mode, pin 0
    wr(8'h14, 32'hAAAA); irqPin = 8'h00; settle(); wr(8'h10, 32'h0);
    @(negedge clk); irqPin = 8'h01;
    @(posedge clk); @(posedge clk); #1;
    check("R10 not yet after two edges", {24'h0, irqReq}, 32'h0);
    @(posedge clk); #1;
    check("R10 set after third edge", {24'h0, irqReq}, 32'h01);

    // R9 detect wins over clear on the same edge (level mode)
    wr(8'h14, 32'h0); irqPin = 8'hFE; settle();
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = 8'h10; regWdata = 32'h0;
    @(posedge clk); #1;
    check("R9 level survives clear", {24'h0, irqReq}, 32'h01);
    @(negedge clk); regValid = 1'b0; regWrite = 1'b0;
    irqPin = 8'hFF; settle(); wr(8'h10, 32'h0);
    rd(8'h10, r); check("R3 clear after pin released", r, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule